// File: doc/BRIEF.md
# Byte-wide PROM configuration serializer

This block leads a serial configuration chain. It reads a byte-wide parallel memory through a 16-bit address and generates the configuration clock itself. The configuration clock is the system clock divided by two. On a rising configuration-clock edge it takes one data byte. On that same edge it moves the address one step, either up or down. Each taken byte then leaves on a single serial line, lowest bit first, so the next device in the chain can sample the stream on its own rising edges.

A one-cycle `start` pulse sets the address to the first location for the chosen direction and starts clocking. The transfer ends in one of two ways: the programmed number of bytes has been taken, or `stop` was pulsed. Every byte already taken is still sent out in full. After that the block parks the clock low, holds the serial line high and raises `done`.

Top module: `prom_cfg_serializer`

## Requirements
- R1: After reset and whenever `busy` is low, `cfg_clk` is 0, `ser_out` is 1, `busy` is 0, and after reset `done` is 0 and `mem_addr` is 0x0000.
- R2: A `start` pulse sampled while idle sets `mem_addr` to 0x0000 when counting up. From the next system clock edge on, `cfg_clk` inverts on every system clock edge while `busy` is high, so one configuration period is two system clocks.
- R3: On a rising `cfg_clk` edge that takes a byte, `mem_data` is captured and `mem_addr` moves by exactly one in the transfer direction. The address changes at no other time during a transfer.
- R4: With `DIR_SEL` = 0 the direction comes from `count_down` sampled with `start` (1 means down, starting at 0xFFFF). `DIR_SEL` = 1 forces up and `DIR_SEL` = 2 forces down, whatever `count_down` is.
- R5: A taken byte is sent lowest bit first. Its bit 0 appears on `ser_out` at the second falling `cfg_clk` edge after the capturing rising edge, which is three system clocks later.
- R6: `ser_out` changes only on system clock edges where `cfg_clk` falls.
- R7: Bytes are taken every eight configuration periods, at system clock edges 1, 17, 33, … after the start edge. The serial stream has no gap bits between consecutive bytes.
- R8: With `byte_total` = N > 0, exactly N bytes are taken. With `byte_total` = 0 the count is unlimited.
- R9: The transfer ends at the falling edge that follows the rising edge on which the last bit is sampled downstream. That is system clock edge 16·N + 4 after start for N bytes. At that edge `busy` drops, `done` rises, `cfg_clk` returns to 0 and `ser_out` returns to 1.
- R10: A `stop` pulse blocks any capture on the edge where it is sampled and on every later edge. Bytes already taken are still sent in full. A stop sampled on edge 1 gives zero bytes and ends at edge 4.
- R11: A `start` sampled while `busy` is high is ignored. `done` stays high until the next accepted `start` clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a transfer (sampled while idle) |
| stop | input | 1 | End the transfer after the bytes already taken |
| count_down | input | 1 | Direction select when DIR_SEL = 0 (1 = down) |
| byte_total | input | ADDR_W | Number of bytes to take; 0 = unlimited |
| mem_data | input | DATA_W | Byte from the parallel memory |
| mem_addr | output | ADDR_W | Address to the parallel memory |
| cfg_clk | output | 1 | Generated configuration clock |
| ser_out | output | 1 | Serial data to the next device in the chain |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | Transfer finished |

## Verification
The bench targets the hand-over between bytes. A design whose load slot is off by one falling edge would drop or repeat the top bit of each byte, or insert a gap bit. The downstream capture queue and the per-clock model both expose that. The bench checks the exact end edge for one, two and three bytes, for an unlimited count ended by `stop`, and for a stop on the very first rising edge. A design that ends one configuration period early cuts off the final bit. One that forgets a pending byte loses it. The bench also sends a `start` in the middle of a transfer and runs a fixed-down instance next to an up transfer, which catches an address counter that reloads or follows the wrong direction source.

// File: rtl/prom_cfg_serializer.sv
module prom_cfg_serializer #(
  parameter int ADDR_W  = 16,
  parameter int DATA_W  = 8,
  parameter int DIR_SEL = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              stop,
  input  logic              count_down,
  input  logic [ADDR_W-1:0] byte_total,
  input  logic [DATA_W-1:0] mem_data,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              cfg_clk,
  output logic              ser_out,
  output logic              busy,
  output logic              done
);
  localparam int BIT_W = $clog2(DATA_W);
  localparam logic [BIT_W-1:0] LAST_RISE = BIT_W'(DATA_W - 1);
  localparam logic [BIT_W-1:0] LOAD_SLOT = BIT_W'(2);

  logic              run, down_q, halt, hold_vld;
  logic [BIT_W-1:0]  rc;
  logic [DATA_W-1:0] hold;
  logic [DATA_W-2:0] sh;
  logic [ADDR_W-1:0] addr, nb, lim;
  logic              dir_now, rise, fall, room, cap, load;

  assign dir_now = (DIR_SEL == 1) ? 1'b0 : (DIR_SEL == 2) ? 1'b1 : count_down;
  assign rise    = run & ~cfg_clk;
  assign fall    = run & cfg_clk;
  assign room    = (lim == '0) || (nb != lim);
  assign cap     = rise && (rc == '0) && !(halt || stop) && room;
  assign load    = fall && (rc == LOAD_SLOT);

  assign mem_addr = addr;
  assign busy     = run;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run      <= 1'b0;
      cfg_clk  <= 1'b0;
      ser_out  <= 1'b1;
      done     <= 1'b0;
      down_q   <= 1'b0;
      halt     <= 1'b0;
      hold_vld <= 1'b0;
      rc       <= '0;
      hold     <= '0;
      sh       <= '1;
      addr     <= '0;
      nb       <= '0;
      lim      <= '0;
    end else if (!run) begin
      if (start) begin
        run      <= 1'b1;
        cfg_clk  <= 1'b0;
        ser_out  <= 1'b1;
        done     <= 1'b0;
        down_q   <= dir_now;
        halt     <= 1'b0;
        hold_vld <= 1'b0;
        rc       <= '0;
        sh       <= '1;
        addr     <= dir_now ? '1 : '0;
        nb       <= '0;
        lim      <= byte_total;
      end
    end else begin
      cfg_clk <= ~cfg_clk;
      if (stop) halt <= 1'b1;
      if (rise) rc <= (rc == LAST_RISE) ? '0 : rc + 1'b1;
      if (cap) begin
        hold     <= mem_data;
        hold_vld <= 1'b1;
        addr     <= down_q ? addr - 1'b1 : addr + 1'b1;
        nb       <= nb + 1'b1;
      end
      if (fall) begin
        if (load && !hold_vld) begin
          run     <= 1'b0;
          done    <= 1'b1;
          ser_out <= 1'b1;
        end else if (load) begin
          ser_out  <= hold[0];
          sh       <= hold[DATA_W-1:1];
          hold_vld <= 1'b0;
        end else begin
          ser_out <= sh[0];
          sh      <= {1'b1, sh[DATA_W-2:1]};
        end
      end
    end
  end
endmodule

// File: rtl/prom_cfg_serializer_chk.sv
module prom_cfg_serializer_chk #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              done,
  input logic              cfg_clk,
  input logic              ser_out,
  input logic [ADDR_W-1:0] mem_addr
);
  AST_IDLE_CLK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !cfg_clk); // R1
  AST_IDLE_SER_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> ser_out); // R1
  AST_CLK_TOGGLES: assert property (@(posedge clk) disable iff (!rst_n)
    busy && $past(busy) |-> cfg_clk != $past(cfg_clk)); // R2
  AST_ADDR_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    busy && $past(busy) && !$stable(mem_addr) |-> $rose(cfg_clk)); // R3
  AST_ADDR_UNIT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    busy && $past(busy) && !$stable(mem_addr) |->
      ((mem_addr - $past(mem_addr)) == ADDR_W'(1) ||
       (mem_addr - $past(mem_addr)) == {ADDR_W{1'b1}})); // R3
  AST_SER_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ser_out) |-> $fell(cfg_clk)); // R6
  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy); // R9
endmodule

bind prom_cfg_serializer prom_cfg_serializer_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done),
  .cfg_clk(cfg_clk), .ser_out(ser_out), .mem_addr(mem_addr)
);

// File: tb/prom_cfg_serializer_tb.sv
module prom_cfg_serializer_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0, stop = 1'b0, count_down = 1'b0;
  logic [15:0] byte_total = '0;
  logic [15:0] mem_addr, dn_addr;
  logic [7:0]  mem_data, dn_data;
  logic        cfg_clk, ser_out, busy, done;
  logic        dn_clk, dn_ser, dn_busy, dn_done;

  int n_chk = 0, n_fail = 0, wd = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [7:0] memf(input logic [15:0] a);
    return a[7:0] ^ {a[3:0], a[15:12]} ^ 8'hA5;
  endfunction

  assign mem_data = memf(mem_addr);
  assign dn_data  = memf(dn_addr);

  prom_cfg_serializer dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .stop(stop), .count_down(count_down),
    .byte_total(byte_total), .mem_data(mem_data), .mem_addr(mem_addr),
    .cfg_clk(cfg_clk), .ser_out(ser_out), .busy(busy), .done(done));

  prom_cfg_serializer #(.DIR_SEL(2)) dut_dn_i (
    .clk(clk), .rst_n(rst_n), .start(start), .stop(stop), .count_down(count_down),
    .byte_total(byte_total), .mem_data(dn_data), .mem_addr(dn_addr),
    .cfg_clk(dn_clk), .ser_out(dn_ser), .busy(dn_busy), .done(dn_done));

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // behavioural reference model
  bit          m_run = 0, m_clk = 0, m_ser = 1, m_done = 0, m_dn = 0, m_halt = 0, m_capd = 0;
  logic [15:0] m_addr = '0, m_lim = '0;
  int          m_t = 0, m_nb = 0;
  int          q_t[$];
  bit          q_b[$];

  always @(posedge clk) begin
    if (!rst_n) begin
      m_run = 0; m_clk = 0; m_ser = 1; m_done = 0; m_addr = '0;
      q_t.delete(); q_b.delete();
    end else if (!m_run) begin
      if (start) begin
        m_run = 1; m_t = 0; m_dn = count_down; m_lim = byte_total;
        m_addr = m_dn ? 16'hFFFF : 16'h0000;
        m_clk = 0; m_ser = 1; m_done = 0; m_nb = 0; m_halt = 0; m_capd = 0;
        q_t.delete(); q_b.delete();
      end
    end else begin
      logic [7:0] b;
      m_t++;
      m_clk = (m_t % 2) == 1;
      if (stop) m_halt = 1;
      if (m_t % 16 == 1) begin
        m_capd = 0;
        if (!m_halt && (m_lim == 0 || m_nb < int'(m_lim))) begin
          b = memf(m_addr);
          for (int k = 0; k < 8; k++) begin
            q_t.push_back(m_t + 3 + 2*k);
            q_b.push_back(b[k]);
          end
          m_addr = m_dn ? m_addr - 16'd1 : m_addr + 16'd1;
          m_nb++;
          m_capd = 1;
        end
      end
      if (m_t % 2 == 0) begin
        if (m_t % 16 == 4 && !m_capd) begin
          m_run = 0; m_done = 1; m_ser = 1; m_clk = 0;
        end else if (q_t.size() > 0 && q_t[0] == m_t) begin
          m_ser = q_b.pop_front();
          void'(q_t.pop_front());
        end
      end
    end
  end

  // per-clock comparison, edge rule and downstream capture
  bit prev_cfg = 0, prev_ser = 1;
  bit rec[$];

  always @(negedge clk) begin
    if (rst_n) begin
      chk(cfg_clk === m_clk, "R2", "cfg_clk", 32'(cfg_clk), 32'(m_clk));
      chk(ser_out === m_ser, "R5", "ser_out", 32'(ser_out), 32'(m_ser));
      chk(mem_addr === m_addr, "R3", "mem_addr", 32'(mem_addr), 32'(m_addr));
      chk(busy === m_run, "R9", "busy", 32'(busy), 32'(m_run));
      chk(done === m_done, "R9", "done", 32'(done), 32'(m_done));
      if (ser_out !== prev_ser)
        chk(prev_cfg && !cfg_clk, "R6", "ser_out moved off a falling edge", 32'(cfg_clk), 32'(0));
      if (cfg_clk && !prev_cfg) rec.push_back(ser_out);
    end
    prev_cfg = cfg_clk;
    prev_ser = ser_out;
  end

  always @(posedge clk) begin
    wd++;
    if (wd >= 20000) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  task automatic kick(input logic dn, input logic [15:0] tot);
    @(negedge clk);
    count_down = dn; byte_total = tot; start = 1'b1;
    rec.delete();
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done(inout int cyc);
    while (!done && cyc < 2000) begin
      @(negedge clk);
      cyc++;
    end
  endtask

  task automatic stream_check(input logic [15:0] base, input bit dn, input int n, input string req);
    chk(rec.size() == 8*n + 2, req, "downstream rising edges", 32'(rec.size()), 32'(8*n + 2));
    for (int j = 0; j < n; j++) begin
      logic [7:0] got, exp;
      exp = memf(dn ? base - 16'(j) : base + 16'(j));
      for (int k = 0; k < 8; k++)
        got[k] = (rec.size() > 2 + 8*j + k) ? rec[2 + 8*j + k] : 1'b0;
      chk(got == exp, (j == 0) ? "R5" : "R7", "serial byte", 32'(got), 32'(exp));
    end
  endtask

  initial begin
    int cyc;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(cfg_clk == 1'b0, "R1", "cfg_clk after reset", 32'(cfg_clk), 0);
    chk(ser_out == 1'b1, "R1", "ser_out after reset", 32'(ser_out), 1);
    chk(busy == 1'b0, "R1", "busy after reset", 32'(busy), 0);
    chk(done == 1'b0, "R1", "done after reset", 32'(done), 0);
    chk(mem_addr == 16'h0000, "R1", "mem_addr after reset", 32'(mem_addr), 0);

    // three bytes counting up
    kick(1'b0, 16'd3);
    chk(mem_addr == 16'h0000, "R2", "start address up", 32'(mem_addr), 32'h0000);
    chk(dn_addr == 16'hFFFF, "R4", "forced-down start address", 32'(dn_addr), 32'hFFFF);
    @(negedge clk);
    cyc = 1;
    chk(mem_addr == 16'h0001, "R3", "address after first capture", 32'(mem_addr), 32'h0001);
    chk(dn_addr == 16'hFFFE, "R4", "forced-down address step", 32'(dn_addr), 32'hFFFE);
    wait_done(cyc);
    chk(cyc == 52, "R8", "end edge for 3 bytes", 32'(cyc), 32'd52);
    stream_check(16'h0000, 1'b0, 3, "R7");
    repeat (5) @(negedge clk);
    chk(done == 1'b1, "R11", "done held while idle", 32'(done), 1);
    chk(cfg_clk == 1'b0, "R9", "cfg_clk parked low", 32'(cfg_clk), 0);
    chk(ser_out == 1'b1, "R9", "ser_out parked high", 32'(ser_out), 1);

    // two bytes counting down, with a start sent mid-transfer
    kick(1'b1, 16'd2);
    chk(mem_addr == 16'hFFFF, "R4", "start address down", 32'(mem_addr), 32'hFFFF);
    chk(done == 1'b0, "R11", "done cleared by start", 32'(done), 0);
    repeat (20) @(negedge clk);
    count_down = 1'b0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cyc = 21;
    chk(mem_addr == 16'hFFFD, "R11", "address after ignored start", 32'(mem_addr), 32'hFFFD);
    chk(busy == 1'b1, "R11", "busy after ignored start", 32'(busy), 1);
    wait_done(cyc);
    chk(cyc == 36, "R9", "end edge for 2 bytes", 32'(cyc), 32'd36);
    stream_check(16'hFFFF, 1'b1, 2, "R7");

    // single byte
    kick(1'b0, 16'd1);
    cyc = 0;
    wait_done(cyc);
    chk(cyc == 20, "R8", "end edge for 1 byte", 32'(cyc), 32'd20);
    stream_check(16'h0000, 1'b0, 1, "R8");

    // unlimited count ended by stop
    kick(1'b0, 16'd0);
    repeat (40) @(negedge clk);
    stop = 1'b1;
    @(negedge clk);
    stop = 1'b0;
    cyc = 41;
    wait_done(cyc);
    chk(cyc == 52, "R10", "end edge after stop", 32'(cyc), 32'd52);
    chk(mem_addr == 16'h0003, "R10", "bytes taken before stop", 32'(mem_addr), 32'h0003);
    stream_check(16'h0000, 1'b0, 3, "R10");

    // stop on the first rising edge
    kick(1'b0, 16'd0);
    stop = 1'b1;
    @(negedge clk);
    stop = 1'b0;
    cyc = 1;
    chk(mem_addr == 16'h0000, "R10", "no capture with early stop", 32'(mem_addr), 0);
    wait_done(cyc);
    chk(cyc == 4, "R10", "end edge with zero bytes", 32'(cyc), 32'd4);
    chk(rec.size() == 2, "R10", "rising edges with zero bytes", 32'(rec.size()), 2);

    repeat (3) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule